// File: doc/BRIEF.md
# Engine Parameter Polling and Scaling Unit

This block polls a vehicle diagnostic adapter for eight engine parameters in turn. For each parameter it builds a short ASCII request and shifts it out on a serial data line, most significant bit first, while a send enable is high. It then gathers the one- or two-byte reply from a serial input that carries a per-bit valid strobe. Finally it converts the raw reply into an engineering value using that parameter's own formula.

An 8-bit enable mask selects which parameters take part in the round-robin schedule. A new request starts only after the previous result has been presented. If a reply stalls, a receive timeout ends the wait. The parameter then appears as stale instead of producing a value. The result bus is qualified by a one-cycle valid pulse and reads as zero at every other time, so it can share a wired bus with other sources.

Top module: `obd_poll_unit`

## Requirements
- R1: Parameters are served in ascending index order among those whose `param_en` bit is set, wrapping after index 7, and starting from index 0 after reset. The mask is sampled when the next parameter is chosen. With an all-zero mask no request is ever sent.
- R2: A request is sent on `tx_bit`, one bit per cycle, MSB first, while `tx_en` is high. `tx_en` stays high for exactly 32 cycles, or 48 cycles for index 2. `tx_bit` is 0 whenever `tx_en` is low.
- R3: Index-to-code table: 0 = 0x05 coolant temperature, 1 = 0x0A fuel pressure, 2 = 0x0C engine speed, 3 = 0x0D vehicle speed, 4 = 0x0F intake temperature, 5 = 0x11 throttle, 6 = 0x46 ambient temperature, 7 = 0x5C oil temperature. The request bytes are ASCII '0', '1', then the two upper-case hex digits of the code. Index 2 appends the bytes 0x20 and 0x31.
- R4: Reply bits are taken only in cycles where `rx_valid` is high, MSB first. Index 2 takes 16 bits (first byte A, second byte B). All other indices take 8 bits (byte A). Bits offered while `rx_valid` is low have no effect on the result.
- R5: Indices 0, 4, 6 and 7 give the signed value A − 40.
- R6: Index 1 gives A × 3. Index 3 gives A.
- R7: Index 2 gives (A × 256 + B) / 4, truncated.
- R8: Index 5 gives A × 100 / 255, truncated.
- R9: In the cycle after the last reply bit is taken, `result_valid` is high for exactly one cycle and `result_param` holds the served index. At every other time `result` is zero.
- R10: If the reply is not complete within `RX_TIMEOUT` cycles of the request ending, a one-cycle pulse appears with `result_valid` and `result_stale` both high and `result` zero. This pulse comes exactly `RX_TIMEOUT` cycles after `tx_en` falls.
- R11: `tx_en` is never high together with `result_valid`. With a non-empty mask, the next request begins two cycles after the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_en | input | 8 | Per-index enable mask for the polling schedule |
| tx_bit | output | 1 | Serial request data, MSB first |
| tx_en | output | 1 | High while request bits are being sent |
| rx_bit | input | 1 | Serial reply data |
| rx_valid | input | 1 | Qualifies `rx_bit` in the current cycle |
| result | output | RES_W | Scaled value, signed, zero when not valid |
| result_valid | output | 1 | One-cycle result strobe |
| result_stale | output | 1 | Marks a strobe caused by a reply timeout |
| result_param | output | 3 | Index of the parameter being served |

## Verification
The bound checker watches, on every cycle, the properties that hold regardless of data: the result bus is zero outside the strobe, the strobe lasts one cycle and never overlaps the send enable, the data line is quiet while idle, the served index was enabled and stays fixed during a request, stale strobes carry zero, and temperature and throttle results stay within range. Only the bench scenarios can show that the request bytes are exactly right, that reply bits arrive in the correct order despite gaps in the strobe, that each formula produces the right number, that the round-robin order follows mask changes, and that the timeout fires in exactly the right cycle.

// File: rtl/obd_poll_pkg.sv
package obd_poll_pkg;

   localparam int N_PID      = 8;
   localparam int IDX_W      = $clog2(N_PID);
   localparam int BYTE_W     = 8;
   localparam int FRAME_BITS = 6 * BYTE_W;
   localparam int SHORT_BITS = 4 * BYTE_W;

   typedef enum logic [2:0] {
      K_TEMP,
      K_FUEL,
      K_RPM,
      K_SPEED,
      K_THROT
   } kind_t;

   function automatic logic [BYTE_W-1:0] pid_code(input logic [IDX_W-1:0] i);
      case (i)
         3'd0:    return 8'h05;
         3'd1:    return 8'h0A;
         3'd2:    return 8'h0C;
         3'd3:    return 8'h0D;
         3'd4:    return 8'h0F;
         3'd5:    return 8'h11;
         3'd6:    return 8'h46;
         default: return 8'h5C;
      endcase
   endfunction

   function automatic kind_t pid_kind(input logic [IDX_W-1:0] i);
      case (i)
         3'd1:    return K_FUEL;
         3'd2:    return K_RPM;
         3'd3:    return K_SPEED;
         3'd5:    return K_THROT;
         default: return K_TEMP;
      endcase
   endfunction

   function automatic logic pid_long(input logic [IDX_W-1:0] i);
      return pid_kind(i) == K_RPM;
   endfunction

   function automatic logic [BYTE_W-1:0] hex_char(input logic [3:0] n);
      return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
   endfunction

   // Request text, left-justified; short frames leave the tail zero.
   function automatic logic [FRAME_BITS-1:0] pid_frame(input logic [IDX_W-1:0] i);
      logic [BYTE_W-1:0] c;
      c = pid_code(i);
      return {8'h30, 8'h31, hex_char(c[7:4]), hex_char(c[3:0]),
              pid_long(i) ? 16'h2031 : 16'h0000};
   endfunction

endpackage

// File: rtl/obd_req_tx.sv
module obd_req_tx
   import obd_poll_pkg::*;
#(
   parameter int FRAME_W = FRAME_BITS
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic [FRAME_W-1:0]             frame,
   input  logic [$clog2(FRAME_W+1)-1:0]   nbits,
   input  logic                           run,
   output logic                           bit_out,
   output logic                           done
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;

   assign bit_out = sh[FRAME_W-1];
   assign done    = run && (cnt == nbits - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (load || done) begin
         sh  <= frame;
         cnt <= '0;
      end else if (run) begin
         sh  <= {sh[FRAME_W-2:0], 1'b0};
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/obd_rsp_rx.sv
module obd_rsp_rx
   import obd_poll_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              bit_in,
   input  logic              two,
   output logic [BYTE_W-1:0] byte_a,
   output logic [BYTE_W-1:0] byte_b,
   output logic              full
);
   localparam int SH_W  = 2 * BYTE_W;
   localparam int CNT_W = $clog2(SH_W + 1);

   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last   = two ? CNT_W'(SH_W - 1) : CNT_W'(BYTE_W - 1);
   assign full   = take && (cnt == last);
   assign byte_a = two ? sh[SH_W-1:BYTE_W] : sh[BYTE_W-1:0];
   assign byte_b = sh[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         sh  <= '0;
         cnt <= '0;
      end else if (take) begin
         sh  <= {sh[SH_W-2:0], bit_in};
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/obd_scale.sv
module obd_scale
   import obd_poll_pkg::*;
#(
   parameter int RES_W = 16
)(
   input  logic              en,
   input  kind_t             kind,
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   output logic [RES_W-1:0]  result
);
   int ia, ib, r;

   always_comb begin
      ia = int'(a);
      ib = int'(b);
      case (kind)
         K_TEMP:  r = ia - 40;
         K_FUEL:  r = ia * 3;
         K_RPM:   r = (ia * 256 + ib) / 4;
         K_SPEED: r = ia;
         K_THROT: r = (ia * 100) / 255;
         default: r = 0;
      endcase
      result = en ? RES_W'(r) : '0;
   end
endmodule

// File: rtl/obd_poll_unit.sv
module obd_poll_unit
   import obd_poll_pkg::*;
#(
   parameter int RES_W      = 16,
   parameter int RX_TIMEOUT = 64
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PID-1:0] param_en,
   output logic             tx_bit,
   output logic             tx_en,
   input  logic             rx_bit,
   input  logic             rx_valid,
   output logic [RES_W-1:0] result,
   output logic             result_valid,
   output logic             result_stale,
   output logic [IDX_W-1:0] result_param
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);

   if (RES_W < 16 || RES_W > 32) begin : g_bad_res
      $error("RES_W must lie in 16..32");
   end
   if (RX_TIMEOUT < 0) begin : g_bad_tmo
      $error("RX_TIMEOUT must not be negative");
   end

   typedef enum logic [1:0] {S_PICK, S_SEND, S_RECV, S_OUT} state_t;

   state_t               state;
   logic [IDX_W-1:0]     cur, nxt, cand, sel;
   logic                 found, stale;
   logic                 load, tx_done, tx_raw, rx_full, tmo_hit;
   logic [FRAME_BITS-1:0] frame;
   logic [CNT_W-1:0]     nbits;
   logic [BYTE_W-1:0]    byte_a, byte_b;

   // Round-robin search starting after the last served index.
   always_comb begin
      found = 1'b0;
      nxt   = cur;
      cand  = cur;
      for (int k = 1; k <= N_PID; k++) begin
         cand = cur + IDX_W'(k);
         if (!found && param_en[cand]) begin
            found = 1'b1;
            nxt   = cand;
         end
      end
   end

   assign sel   = (state == S_PICK) ? nxt : cur;
   assign frame = pid_frame(sel);
   assign nbits = pid_long(sel) ? CNT_W'(FRAME_BITS) : CNT_W'(SHORT_BITS);
   assign load  = (state == S_PICK) && found;

   obd_req_tx #(.FRAME_W(FRAME_BITS)) i_tx (
      .clk(clk), .rst_n(rst_n), .load(load), .frame(frame), .nbits(nbits),
      .run(state == S_SEND), .bit_out(tx_raw), .done(tx_done)
   );

   obd_rsp_rx i_rx (
      .clk(clk), .rst_n(rst_n), .clear(load),
      .take((state == S_RECV) && rx_valid), .bit_in(rx_bit),
      .two(pid_long(cur)), .byte_a(byte_a), .byte_b(byte_b), .full(rx_full)
   );

   if (RX_TIMEOUT > 0) begin : g_tmo
      localparam int TMO_W = $clog2(RX_TIMEOUT + 1);
      logic [TMO_W-1:0] tmo_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || state != S_RECV) tmo_cnt <= '0;
         else                           tmo_cnt <= tmo_cnt + TMO_W'(1);
      end
      assign tmo_hit = (state == S_RECV) && (tmo_cnt == TMO_W'(RX_TIMEOUT - 1));
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_PICK;
         cur   <= IDX_W'(N_PID - 1);
         stale <= 1'b0;
      end else begin
         case (state)
            S_PICK: if (found) begin
               cur   <= nxt;
               state <= S_SEND;
            end
            S_SEND: if (tx_done) state <= S_RECV;
            S_RECV: if (rx_full) begin
               state <= S_OUT;
               stale <= 1'b0;
            end else if (tmo_hit) begin
               state <= S_OUT;
               stale <= 1'b1;
            end
            default: state <= S_PICK;
         endcase
      end
   end

   assign tx_en        = (state == S_SEND);
   assign tx_bit       = tx_en && tx_raw;
   assign result_valid = (state == S_OUT);
   assign result_stale = result_valid && stale;
   assign result_param = cur;

   obd_scale #(.RES_W(RES_W)) i_scale (
      .en(result_valid && !stale), .kind(pid_kind(cur)),
      .a(byte_a), .b(byte_b), .result(result)
   );
endmodule

// File: rtl/obd_poll_checker.sv
module obd_poll_checker
   import obd_poll_pkg::*;
#(
   parameter int RES_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic [N_PID-1:0] param_en,
   input logic             tx_bit,
   input logic             tx_en,
   input logic [RES_W-1:0] result,
   input logic             result_valid,
   input logic             result_stale,
   input logic [IDX_W-1:0] result_param
);
   logic [N_PID-1:0] en_q;
   logic             is_temp;

   always_ff @(posedge clk) en_q <= param_en;

   assign is_temp = (result_param == 3'd0) || (result_param == 3'd4) ||
                    (result_param == 3'd6) || (result_param == 3'd7);

   a_r9_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> result == '0);

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !tx_en);

   a_r2_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_bit);

   a_r2_param_steady: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |=> (!tx_en || $stable(result_param)));

   a_r1_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> en_q[result_param]);

   a_r10_stale_zero: assert property (@(posedge clk) disable iff (!rst_n)
      result_stale |-> (result_valid && result == '0));

   a_r5_temp_range: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !result_stale && is_temp) |->
         ($signed(result) >= -40 && $signed(result) <= 215));

   a_r8_throttle_max: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !result_stale && result_param == 3'd5) |->
         (result <= RES_W'(100)));
endmodule

bind obd_poll_unit obd_poll_checker #(.RES_W(RES_W)) i_obd_poll_checker (
   .clk(clk), .rst_n(rst_n), .param_en(param_en), .tx_bit(tx_bit),
   .tx_en(tx_en), .result(result), .result_valid(result_valid),
   .result_stale(result_stale), .result_param(result_param)
);

// File: tb/test_obd_poll_unit.sv
module test_obd_poll_unit;
   localparam int TMO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  param_en;
   logic        tx_bit, tx_en, rx_bit, rx_valid;
   logic [15:0] result;
   logic        result_valid, result_stale;
   logic [2:0]  result_param;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   logic [2:0] exp_idx = 3'd7;

   always #5 clk = ~clk;

   obd_poll_unit #(.RES_W(16), .RX_TIMEOUT(TMO)) i_obd_poll_unit (
      .clk(clk), .rst_n(rst_n), .param_en(param_en), .tx_bit(tx_bit),
      .tx_en(tx_en), .rx_bit(rx_bit), .rx_valid(rx_valid), .result(result),
      .result_valid(result_valid), .result_stale(result_stale),
      .result_param(result_param)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] code_of(input logic [2:0] i);
      logic [7:0] t [8] = '{8'h05, 8'h0A, 8'h0C, 8'h0D, 8'h0F, 8'h11, 8'h46, 8'h5C};
      return t[i];
   endfunction

   function automatic logic [7:0] asc(input logic [3:0] n);
      return (n > 4'd9) ? 8'd65 + 8'(n - 4'd10) : 8'd48 + 8'(n);
   endfunction

   function automatic logic [47:0] exp_frame(input logic [2:0] i);
      logic [7:0] c = code_of(i);
      logic [47:0] f = {"0", "1", asc(c[7:4]), asc(c[3:0]), 16'h0};
      if (i == 3'd2) f[15:0] = {8'h20, 8'h31};
      return f;
   endfunction

   function automatic int exp_value(input logic [2:0] i, input logic [7:0] a, input logic [7:0] b);
      case (i)
         3'd1:    return int'(a) * 3;
         3'd2:    return (int'(a) * 256 + int'(b)) / 4;
         3'd3:    return int'(a);
         3'd5:    return (int'(a) * 100) / 255;
         default: return int'(a) - 40;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] i);
      case (i)
         3'd1, 3'd3: return "R4 R6";
         3'd2:       return "R4 R7";
         3'd5:       return "R4 R8";
         default:    return "R4 R5";
      endcase
   endfunction

   function automatic logic [2:0] next_idx(input logic [2:0] c, input logic [7:0] m);
      for (int k = 1; k <= 8; k++)
         if (m[3'(c + 3'(k))]) return 3'(c + 3'(k));
      return c;
   endfunction

   // One poll: check request, feed reply (or part of it), check result.
   task automatic txn(input logic [7:0] a, input logic [7:0] b, input int gap_max,
                      input int send_bits, input logic [7:0] next_mask);
      int          wait_n = 0;
      int          nb = 0;
      int          cyc = 0;
      int          need, sends;
      bit          two, quiet;
      logic [47:0] got = '0;
      logic [15:0] reply;
      exp_idx = next_idx(exp_idx, param_en);
      two     = (exp_idx == 3'd2);
      need    = two ? 16 : 8;
      reply   = two ? {a, b} : {8'h00, a};
      sends   = (send_bits < 0) ? need : send_bits;
      while (!tx_en && wait_n < 100) begin
         @(negedge clk);
         wait_n++;
      end
      check(tx_en, "R1 request start", longint'(tx_en), 1);
      while (tx_en) begin
         got = {got[46:0], tx_bit};
         nb++;
         @(negedge clk);
      end
      check(nb == (two ? 48 : 32), "R2 request length", nb, two ? 48 : 32);
      if (two) check(got == exp_frame(exp_idx), "R3 frame", got, exp_frame(exp_idx));
      else check(got[31:0] == exp_frame(exp_idx)[47:16], "R3 frame",
                 got[31:0], exp_frame(exp_idx)[47:16]);
      quiet = 1'b1;
      for (int s = 0; s < sends; s++) begin
         int g = $urandom_range(gap_max, 0);
         repeat (g) begin
            rx_valid = 1'b0;
            rx_bit   = 1'($urandom_range(1, 0));
            if (result_valid || result != 16'd0) quiet = 1'b0;
            @(negedge clk);
            cyc++;
         end
         rx_valid = 1'b1;
         rx_bit   = reply[need-1-s];
         if (result_valid || result != 16'd0) quiet = 1'b0;
         @(negedge clk);
         cyc++;
      end
      rx_valid = 1'b0;
      rx_bit   = 1'b0;
      if (send_bits >= 0) begin
         while (!result_valid && cyc < TMO + 5) begin
            if (result != 16'd0) quiet = 1'b0;
            @(negedge clk);
            cyc++;
         end
         check(cyc == TMO, "R10 timeout cycle", cyc, TMO);
      end
      check(quiet, "R9 bus zero before result", 0, 1);
      check(result_valid, "R9 result strobe", longint'(result_valid), 1);
      check(result_param == exp_idx, "R1 served index", result_param, exp_idx);
      check(result_stale == (send_bits >= 0), "R10 stale flag", result_stale, send_bits >= 0);
      if (send_bits >= 0)
         check(result == 16'd0, "R10 stale value", result, 0);
      else
         check($signed(result) == exp_value(exp_idx, a, b), req_of(exp_idx),
               $signed(result), exp_value(exp_idx, a, b));
      param_en = next_mask;
      @(negedge clk);
      check(!result_valid && !tx_en && result == 16'd0, "R9 R11 pulse ends",
            longint'(result_valid), 0);
      @(negedge clk);
      check(tx_en == (next_mask != 8'd0), "R11 next request start",
            longint'(tx_en), next_mask != 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R9: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      param_en = 8'hFF;
      rx_valid = 1'b0;
      rx_bit   = 1'b0;
      repeat (3) @(negedge clk);
      check(!tx_en && !tx_bit && !result_valid && result == 16'd0,
            "R9 reset outputs", longint'(tx_en) + longint'(result_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: every index once, with boundary bytes.
      txn(8'd0,   8'd0,   0, -1, 8'hFF);   // temp floor -40
      txn(8'd255, 8'd0,   1, -1, 8'hFF);   // fuel 765
      txn(8'd255, 8'd255, 2, -1, 8'hFF);   // rpm max 16383
      txn(8'd200, 8'd0,   0, -1, 8'hFF);   // speed
      txn(8'd255, 8'd0,   0, -1, 8'hFF);   // temp ceiling 215
      txn(8'd255, 8'd0,   2, -1, 8'hFF);   // throttle 100
      txn(8'd40,  8'd0,   0, -1, 8'hFF);   // temp zero
      txn(8'd128, 8'd0,   1, -1, 8'h24);   // oil temp, then mask 2 and 5
      txn(8'h1A,  8'hF9,  1, -1, 8'h24);   // rpm truncation
      txn(8'd128, 8'd0,   0, -1, 8'h24);   // throttle truncation 50
      txn(8'd0,   8'd0,   0,  0, 8'h24);   // rpm timeout, no bits
      txn(8'd0,   8'd0,   1,  5, 8'h00);   // throttle timeout after 5 bits, then mask off

      repeat (20) begin
         @(negedge clk);
         check(!tx_en, "R1 empty mask idle", longint'(tx_en), 0);
      end
      param_en = 8'h81;
      txn(8'd90, 8'd0, 1, -1, 8'h81);

      for (int n = 0; n < 40; n++) begin
         logic [7:0] m = 8'($urandom_range(255, 1));
         txn(8'($urandom_range(255, 0)), 8'($urandom_range(255, 0)), 2, -1, m);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule